// File: doc/BRIEF.md
# Start-of-Frame Wake Detector

This block is the receive front end that stays awake while the rest of a serial receiver has its clock gated. It runs on an always-on slow clock, synchronises the receive line through a two-flop chain and looks for a falling edge, the leading edge of a start bit. When it sees one, it raises a request for the fast oscillator and the receiver clock. It keeps that request up until the receiver reports a finished frame, or until a timeout expires because the oscillator never reported ready.

The wake policy is set by a single enable. With the receive-start wake enabled, the CPU gets a wake pulse in the same cycle as the clock request. With it disabled, the clock request alone carries the frame, and the CPU is woken only by the receive-complete pulse at the end. The edge detector does not depend on whether the receiver is framed asynchronously or with a shared clock, so it serves both.

Top module: `sof_wake_detector`

## Requirements
- R1: After reset `osc_req`, `wake_start` and `wake_done` are 0. While `detect_en` is 0 and no frame is in progress, falling edges on `rx_line` never raise `osc_req`.
- R2: With `detect_en` = 1 and no frame in progress, a 1-to-0 change on `rx_line` first sampled at clock edge n makes `osc_req` read 1 after edge n+2.
- R3: If `start_irq_en` is 1 at the edge that registers the start, `wake_start` is 1 for exactly the cycle in which `osc_req` rises. If it is 0, `wake_start` stays 0.
- R4: Once raised, `osc_req` stays 1 until `frame_done` is sampled at 1, and falls after that edge, whatever `rx_line` does in the meantime.
- R5: `frame_done` sampled at 1 while `osc_req` is 1 gives a one-cycle `wake_done` pulse in the cycle in which `osc_req` falls. A `frame_done` while `osc_req` is 0 has no effect.
- R6: Falling edges on `rx_line` while `osc_req` is 1 produce no further `wake_start` and do not restart the frame.
- R7: If `osc_ready` is not sampled at 1 within TIMEOUT_CYC cycles, `osc_req` is 1 for exactly TIMEOUT_CYC cycles and then drops with no `wake_done`. Once `osc_ready` has been seen, the timeout no longer applies.
- R8: After a frame ends, by `frame_done` or by timeout, the next falling edge is detected again as in R2.
- R9: Clearing `detect_en` during a frame does not cut `osc_req`. The frame completes normally, and the block then stays disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Asynchronous receive line, idle high |
| detect_en | input | 1 | Arms the start detector |
| start_irq_en | input | 1 | Selects a wake on the start edge |
| osc_ready | input | 1 | Fast oscillator running |
| frame_done | input | 1 | Receiver finished a frame (pulse) |
| osc_req | output | 1 | Request for fast oscillator and receiver clock |
| wake_start | output | 1 | One-cycle wake on a detected start |
| wake_done | output | 1 | One-cycle wake on frame completion |

## Verification
Directed runs measure the start-to-request latency and the exact timeout length. They toggle the line inside a frame to show that edges there are ignored, and they run the same frame with and without the start wake, so the two wake policies can be told apart. A disable during a frame and a stray completion pulse while idle separate the arm logic from the frame-end logic. A long seeded random phase then mixes line glitches, late or missing oscillator-ready, and enable changes. Every cycle of it is compared against a bench model of the armed, waiting and in-frame states, which catches ordering errors between completion, ready and timeout.

// File: rtl/sof_wake_pkg.sv
package sof_wake_pkg;

  typedef enum logic [1:0] {
    SW_OFF      = 2'd0,
    SW_ARMED    = 2'd1,
    SW_WAIT_CLK = 2'd2,
    SW_IN_FRAME = 2'd3
  } sw_state_e;

  // A frame is in progress from the start edge until completion or timeout.
  function automatic logic sw_busy(input sw_state_e s);
    return (s == SW_WAIT_CLK) || (s == SW_IN_FRAME);
  endfunction

  // True when a count has reached the last waiting cycle of a window.
  function automatic logic sw_window_last(input int unsigned cnt,
                                          input int unsigned limit);
    return cnt == (limit - 1);
  endfunction

endpackage

// File: rtl/sof_rx_edge.sv
module sof_rx_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  output logic fall_o
);
  localparam int CHAIN = SYNC_STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  generate
    for (genvar g = 0; g < CHAIN; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= rx_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b1;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  // Synchronised level low now, high one cycle earlier.
  assign fall_o = chain_q[CHAIN-1] & ~chain_q[CHAIN-2];

endmodule

// File: rtl/sof_clk_timeout.sv
module sof_clk_timeout #(
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic last_o
);
  import sof_wake_pkg::*;

  localparam int CW = $clog2(TIMEOUT_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!last_o) cnt_q <= cnt_q + CW'(1);
  end

  assign last_o = run_i && sw_window_last(int'(cnt_q), TIMEOUT_CYC);

endmodule

// File: rtl/sof_wake_fsm.sv
module sof_wake_fsm (
  input  logic clk,
  input  logic rst_n,
  input  logic detect_en,
  input  logic start_irq_en,
  input  logic osc_ready,
  input  logic frame_done,
  input  logic fall_i,
  input  logic window_last_i,
  output logic waiting_o,
  output logic busy_o,
  output logic start_evt_o,
  output logic timeout_evt_o,
  output logic wake_start_o,
  output logic wake_done_o
);
  import sof_wake_pkg::*;

  sw_state_e state_q, state_d;
  logic      wake_start_q, wake_done_q;

  assign busy_o        = sw_busy(state_q);
  assign waiting_o     = (state_q == SW_WAIT_CLK);
  assign start_evt_o   = (state_q == SW_ARMED) && detect_en && fall_i;
  // Completion wins over ready, ready wins over expiry.
  assign timeout_evt_o = waiting_o && !frame_done && !osc_ready && window_last_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SW_OFF:      if (detect_en) state_d = SW_ARMED;
      SW_ARMED: begin
        if (!detect_en)       state_d = SW_OFF;
        else if (start_evt_o) state_d = SW_WAIT_CLK;
      end
      SW_WAIT_CLK: begin
        if (frame_done)         state_d = SW_ARMED;
        else if (osc_ready)     state_d = SW_IN_FRAME;
        else if (timeout_evt_o) state_d = SW_ARMED;
      end
      SW_IN_FRAME: if (frame_done) state_d = SW_ARMED;
      default:     state_d = SW_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SW_OFF;
      wake_start_q <= 1'b0;
      wake_done_q  <= 1'b0;
    end else begin
      state_q      <= state_d;
      wake_start_q <= start_evt_o && start_irq_en;
      wake_done_q  <= busy_o && frame_done;
    end
  end

  assign wake_start_o = wake_start_q;
  assign wake_done_o  = wake_done_q;

endmodule

// File: rtl/sof_wake_detector.sv
module sof_wake_detector #(
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_line,
  input  logic detect_en,
  input  logic start_irq_en,
  input  logic osc_ready,
  input  logic frame_done,
  output logic osc_req,
  output logic wake_start,
  output logic wake_done
);
  // Internal events brought out for the checker.
  logic fall_evt;
  logic window_last;
  logic waiting;
  logic busy;
  logic start_evt;
  logic timeout_evt;

  sof_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_line),
    .fall_o (fall_evt)
  );

  sof_clk_timeout #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (waiting),
    .last_o (window_last)
  );

  sof_wake_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .detect_en     (detect_en),
    .start_irq_en  (start_irq_en),
    .osc_ready     (osc_ready),
    .frame_done    (frame_done),
    .fall_i        (fall_evt),
    .window_last_i (window_last),
    .waiting_o     (waiting),
    .busy_o        (busy),
    .start_evt_o   (start_evt),
    .timeout_evt_o (timeout_evt),
    .wake_start_o  (wake_start),
    .wake_done_o   (wake_done)
  );

  assign osc_req = busy;

endmodule

// File: rtl/sof_wake_checker.sv
module sof_wake_checker (
  input logic clk,
  input logic rst_n,
  input logic detect_en,
  input logic start_irq_en,
  input logic frame_done,
  input logic osc_req,
  input logic wake_start,
  input logic wake_done,
  input logic busy,
  input logic start_evt,
  input logic timeout_evt
);

  a_r1_rise_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(osc_req) |-> $past(detect_en));

  a_r2_req_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> osc_req);

  a_r3_wake_when_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && start_irq_en) |=> wake_start);

  a_r3_wake_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    wake_start |-> $past(start_evt && start_irq_en));

  a_r3_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
    wake_start |=> !wake_start);

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_req && !frame_done && !timeout_evt) |=> osc_req);

  a_r5_done_ends_req: assert property (@(posedge clk) disable iff (!rst_n)
    wake_done |-> !osc_req);

  a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start_evt);

  a_r7_timeout_silent: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> (!osc_req && !wake_done));

endmodule

bind sof_wake_detector sof_wake_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .detect_en    (detect_en),
  .start_irq_en (start_irq_en),
  .frame_done   (frame_done),
  .osc_req      (osc_req),
  .wake_start   (wake_start),
  .wake_done    (wake_done),
  .busy         (busy),
  .start_evt    (start_evt),
  .timeout_evt  (timeout_evt)
);

// File: tb/sof_wake_detector_tb_top.sv
`timescale 1ns/1ps
module sof_wake_detector_tb_top;
  localparam int TMO = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_line = 1'b1, detect_en = 1'b0, start_irq_en = 1'b0;
  logic osc_ready = 1'b0, frame_done = 1'b0;
  logic osc_req, wake_start, wake_done;

  int n_chk = 0, n_bad = 0;
  bit model_on = 1'b0;
  bit finished = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  sof_wake_detector #(.SYNC_STAGES(2), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .detect_en(detect_en),
    .start_irq_en(start_irq_en), .osc_ready(osc_ready), .frame_done(frame_done),
    .osc_req(osc_req), .wake_start(wake_start), .wake_done(wake_done));

  // ---------------- bench model: off=0 armed=1 waiting=2 frame=3 ----------
  logic sy1, sy2, sy3;
  int   ms, mc;
  logic e_req, e_ws, e_wd;

  function automatic logic start_seen(input logic older, input logic newer);
    return older && !newer;
  endfunction

  function automatic logic expiry(input int count);
    return count + 1 >= TMO;
  endfunction

  assign e_req = (ms >= 2);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1 <= 1'b1; sy2 <= 1'b1; sy3 <= 1'b1;
      ms <= 0; mc <= 0; e_ws <= 1'b0; e_wd <= 1'b0;
    end else begin
      sy1 <= rx_line; sy2 <= sy1; sy3 <= sy2;
      e_ws <= (ms == 1) && detect_en && start_seen(sy3, sy2) && start_irq_en;
      e_wd <= (ms >= 2) && frame_done;
      if (ms == 0) begin
        if (detect_en) ms <= 1;
      end else if (ms == 1) begin
        if (!detect_en) ms <= 0;
        else if (start_seen(sy3, sy2)) begin ms <= 2; mc <= 0; end
      end else if (ms == 2) begin
        if (frame_done) ms <= 1;
        else if (osc_ready) ms <= 3;
        else if (expiry(mc)) ms <= 1;
        else mc <= mc + 1;
      end else begin
        if (frame_done) ms <= 1;
      end
    end
  end

  task automatic check(input string tag, input string what,
                       input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !finished) begin
      check(phase, "osc_req (R2/R4)", osc_req, e_req);
      check(phase, "wake_start (R3)", wake_start, e_ws);
      check(phase, "wake_done (R5)", wake_done, e_wd);
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Drop the line and count negedges until the request appears.
  task automatic start_edge(input string tag);
    int lat;
    lat = 0;
    rx_line = 1'b0;
    while (osc_req !== 1'b1 && lat < 10) begin @(negedge clk); lat++; end
    n_chk++;
    if (lat != 3) begin
      n_bad++;
      $display("FAIL %s start latency: actual %0d expected 3", tag, lat);
    end
  endtask

  task automatic end_frame();
    frame_done = 1'b1; tick(1); frame_done = 1'b0; osc_ready = 1'b0;
    rx_line = 1'b1; tick(4);
  endtask

  initial begin : watchdog
    #(4 * 190000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    int len;
    void'($urandom(32'h5EED_0042));
    tick(3);
    // R1: reset state
    check("R1", "osc_req reset", osc_req, 1'b0);
    check("R1", "wake_start reset", wake_start, 1'b0);
    check("R1", "wake_done reset", wake_done, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    model_on = 1'b1;
    // R1: edges while disarmed
    phase = "R1";
    for (int k = 0; k < 4; k++) begin rx_line = 1'b0; tick(3); rx_line = 1'b1; tick(3); end
    check("R1", "no request while disarmed", osc_req, 1'b0);

    // R2, R3: start with start wake enabled
    phase = "R3"; detect_en = 1'b1; start_irq_en = 1'b1; tick(3);
    start_edge("R2");
    check("R3", "wake_start with request", wake_start, 1'b1);
    tick(1);
    check("R3", "wake_start single cycle", wake_start, 1'b0);
    osc_ready = 1'b1;
    // R4, R6: line toggles inside frame
    phase = "R6";
    for (int k = 0; k < 6; k++) begin rx_line = ~rx_line; tick(2); end
    check("R4", "request held across frame", osc_req, 1'b1);
    check("R6", "no second wake_start", wake_start, 1'b0);
    tick(TMO + 4);
    check("R7", "no timeout after ready", osc_req, 1'b1);
    phase = "R5"; frame_done = 1'b1; tick(1); frame_done = 1'b0;
    check("R5", "wake_done pulse", wake_done, 1'b1);
    check("R4", "request dropped", osc_req, 1'b0);
    tick(1);
    check("R5", "wake_done single", wake_done, 1'b0);
    osc_ready = 1'b0; rx_line = 1'b1; tick(4);
    // R5: stray completion while idle
    frame_done = 1'b1; tick(1); frame_done = 1'b0;
    check("R5", "idle frame_done ignored", wake_done, 1'b0);

    // R8, R3: start wake disabled, only completion wakes
    phase = "R8"; start_irq_en = 1'b0;
    start_edge("R8");
    check("R3", "no wake_start when disabled", wake_start, 1'b0);
    tick(2); osc_ready = 1'b1; tick(5);
    end_frame();

    // R7: timeout without ready
    phase = "R7";
    rx_line = 1'b0;
    while (osc_req !== 1'b1) @(negedge clk);
    len = 0;
    while (osc_req === 1'b1 && len < 100) begin @(negedge clk); len++; end
    n_chk++;
    if (len != TMO) begin
      n_bad++;
      $display("FAIL R7 timeout length: actual %0d expected %0d", len, TMO);
    end
    check("R7", "no wake_done on timeout", wake_done, 1'b0);
    rx_line = 1'b1; tick(4);

    // R9: disable during frame
    phase = "R9"; start_irq_en = 1'b1;
    start_edge("R9");
    detect_en = 1'b0; osc_ready = 1'b1; tick(TMO + 2);
    check("R9", "request kept after disable", osc_req, 1'b1);
    end_frame();
    rx_line = 1'b0; tick(5);
    check("R9", "disarmed after frame", osc_req, 1'b0);
    rx_line = 1'b1; tick(3);

    // R8: seeded random traffic against the model
    phase = "R8";
    detect_en = 1'b1;
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      if ($urandom_range(9) == 0) rx_line = ~rx_line;
      osc_ready  = ($urandom_range(11) == 0) ? 1'b1 : (osc_ready && osc_req);
      frame_done = ($urandom_range(29) == 0);
      if ($urandom_range(79) == 0) detect_en = ~detect_en;
      if ($urandom_range(39) == 0) start_irq_en = ~start_irq_en;
    end
    frame_done = 1'b0; tick(2);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule